// File: doc/BRIEF.md
# Modem Control and Status Registers with Loopback

This block holds the two modem-handshake registers of a serial port controller. The control register drives four outgoing handshake pins (data-terminal-ready, request-to-send and two general outputs) and a loopback enable that the serial data path uses. The status register shows the synchronised state of four incoming lines (clear-to-send, data-set-ready, ring, carrier detect) and keeps a sticky change flag for each line. A modem-status interrupt request is raised while any change flag is set.

A bus front end selects one of the two registers with `sel` and issues single-cycle `wr_en` or `rd_en` strobes. Read data is combinational from the selected register, so the value is valid in the same cycle as the strobe. A status read returns the current flags and then clears them at the following clock edge. In loopback mode the outgoing pins are parked inactive and a status read shows the control outputs folded back onto the line positions. This allows software to test the handshake path without external wiring.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control register reads 0x08, with only the OUT2 bit set and `out2_o` high. The status register reads 0xB0 and `msi_req` is low.
- R2: A control write (`sel`=0) stores `wdata[4:0]`. The field layout is bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback. Bits 7:5 always read 0. Outside loopback the pins `dtr_o`, `rts_o`, `out1_o` and `out2_o` follow the stored bits on the next cycle.
- R3: Status bits 7:4 show the synchronised lines: bit4 CTS, bit5 DSR, bit6 RI, bit7 DCD. The value appears no later than SYNC_STAGES+1 cycles after the input changes.
- R4: Outside loopback, a change of CTS, DSR or DCD sets the matching change flag: bit0, bit1 or bit3 respectively. The ring flag (bit2) is set only when RI falls from 1 to 0. A rising RI leaves it clear.
- R5: A status read (`sel`=1, `rd_en`) returns the flags as they were, then clears all four. A line change that lands in the same cycle as the read still sets its flag.
- R6: `msi_req` is high exactly while at least one change flag is set.
- R7: While the loopback bit is set, `loop_o` is high and all four outgoing handshake pins are low.
- R8: In loopback, a status read returns OUT2 at bit7, OUT1 at bit6, DTR at bit5 and RTS at bit4, with bits 3:0 zero. In this mode external line changes set no flag, and a status read does not clear flags stored earlier. Bits 7:4 keep tracking the lines, so leaving loopback produces no flag.
- R9: A write with `sel`=1 changes neither register.
- R10: Change flags accumulate. Several changes on different lines before a read leave every corresponding flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cts | input | 1 | Asynchronous clear-to-send line, high = asserted |
| line_dsr | input | 1 | Asynchronous data-set-ready line |
| line_ri | input | 1 | Asynchronous ring line |
| line_dcd | input | 1 | Asynchronous carrier-detect line |
| sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect on status only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| dtr_o | output | 1 | Data-terminal-ready pin |
| rts_o | output | 1 | Request-to-send pin |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loop_o | output | 1 | Loopback enable for the data path |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with the default two-stage synchroniser. With that depth, the edge at which a line change reaches the status register is known exactly. This lets the bench place a status read in the same cycle as a flag being set, covering the read-versus-set race. It also allows line changes to be steered into loopback windows, so the frozen flags and the clean exit from loopback are observed through the read port.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int REG_W  = 8;
  localparam int LINE_W = 4;
  localparam int CTL_W  = 5;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mline_t;

  typedef struct packed {
    logic loop_en;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  localparam mctl_t  CTL_RST  = 5'b01000;
  localparam mline_t LINE_RST = 4'b1011;

  // Change flags: plain XOR, except the ring flag marks only a 1->0 fall.
  function automatic logic [LINE_W-1:0] delta_of(mline_t prev, mline_t cur);
    logic [LINE_W-1:0] d;
    d    = prev ^ cur;
    d[2] = prev.ri & ~cur.ri;
    return d;
  endfunction

  // Status view while looped back: control outputs folded onto line slots.
  function automatic logic [REG_W-1:0] loop_view(mctl_t c);
    return {c.out2, c.out1, c.dtr, c.rts, {LINE_W{1'b0}}};
  endfunction
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mcs_ctl_reg.sv
module mcs_ctl_reg
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CTL_W-1:0] wbits,
  output mctl_t            ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (wr_stb) ctl_q <= mctl_t'(wbits);
  end
endmodule

// File: rtl/mcs_stat_reg.sv
module mcs_stat_reg
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mline_t            line_s,
  input  logic              loop_en,
  input  logic              rd_clr,
  output mline_t            lines_q,
  output logic [LINE_W-1:0] delta_q,
  output logic              chg_evt,
  output logic              ri_fall_evt
);
  logic [LINE_W-1:0] new_flags;
  logic [LINE_W-1:0] delta_nxt;

  assign new_flags   = loop_en ? '0 : delta_of(lines_q, line_s);
  assign chg_evt     = !loop_en && (line_s != lines_q);
  assign ri_fall_evt = !loop_en && lines_q.ri && !line_s.ri;
  assign delta_nxt   = (rd_clr ? '0 : delta_q) | new_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= LINE_RST;
      delta_q <= '0;
    end else begin
      lines_q <= line_s;
      delta_q <= delta_nxt;
    end
  end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_cts,
  input  logic             line_dsr,
  input  logic             line_ri,
  input  logic             line_dcd,
  input  logic             sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             dtr_o,
  output logic             rts_o,
  output logic             out1_o,
  output logic             out2_o,
  output logic             loop_o,
  output logic             msi_req
);
  mline_t            line_raw;
  mline_t            line_s;
  mline_t            stat_lines;
  logic [LINE_W-1:0] stat_delta;
  mctl_t             ctl;
  logic              chg_evt;
  logic              ri_fall_evt;
  logic              stat_rd_clr;
  logic              unused_wbits;

  assign line_raw     = {line_dcd, line_ri, line_dsr, line_cts};
  assign unused_wbits = ^wdata[REG_W-1:CTL_W];

  mcs_sync #(
    .STAGES (SYNC_STAGES),
    .W      (LINE_W),
    .RST_VAL(LINE_RST)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_raw),
    .q    (line_s)
  );

  mcs_ctl_reg ctl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_stb(wr_en && !sel),
    .wbits (wdata[CTL_W-1:0]),
    .ctl_q (ctl)
  );

  assign stat_rd_clr = rd_en && sel && !ctl.loop_en;

  mcs_stat_reg stat_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_s     (line_s),
    .loop_en    (ctl.loop_en),
    .rd_clr     (stat_rd_clr),
    .lines_q    (stat_lines),
    .delta_q    (stat_delta),
    .chg_evt    (chg_evt),
    .ri_fall_evt(ri_fall_evt)
  );

  always_comb begin
    if (!sel)             rdata = {{(REG_W-CTL_W){1'b0}}, ctl};
    else if (ctl.loop_en) rdata = loop_view(ctl);
    else                  rdata = {stat_lines, stat_delta};
  end

  assign loop_o  = ctl.loop_en;
  assign dtr_o   = ctl.dtr  && !ctl.loop_en;
  assign rts_o   = ctl.rts  && !ctl.loop_en;
  assign out1_o  = ctl.out1 && !ctl.loop_en;
  assign out2_o  = ctl.out2 && !ctl.loop_en;
  assign msi_req = |stat_delta;
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [4:0] wlo,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o,
  input logic       loop_o,
  input logic       msi_req,
  input logic [3:0] stat_delta,
  input logic       chg_evt,
  input logic       ri_fall_evt
);
  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel && !wlo[4]) |=> (dtr_o == $past(wlo[0]) && rts_o == $past(wlo[1])
                                    && out1_o == $past(wlo[2]) && out2_o == $past(wlo[3]) && !loop_o));

  assert_loop_pins_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_o |-> !(dtr_o || rts_o || out1_o || out2_o));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel && !loop_o && !chg_evt) |=> (stat_delta == 4'b0));

  assert_ring_trailing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_delta[2]) |-> $past(ri_fall_evt));

  assert_msi_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_req) |-> $past(chg_evt));

  assert_loop_no_new_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_o) |-> ((stat_delta & ~$past(stat_delta)) == 4'b0));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wlo        (wdata[4:0]),
  .dtr_o      (dtr_o),
  .rts_o      (rts_o),
  .out1_o     (out1_o),
  .out2_o     (out2_o),
  .loop_o     (loop_o),
  .msi_req    (msi_req),
  .stat_delta (stat_delta),
  .chg_evt    (chg_evt),
  .ri_fall_evt(ri_fall_evt)
);

// File: tb/modem_ctl_stat_tb_top.sv
`timescale 1ns/1ps
module modem_ctl_stat_tb_top;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_cts = 1'b1, line_dsr = 1'b1, line_ri = 1'b0, line_dcd = 1'b1;
  logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       dtr_o, rts_o, out1_o, out2_o, loop_o, msi_req;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  modem_ctl_stat #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
    .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
    .loop_o(loop_o), .msi_req(msi_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk); sel = s; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic s, output logic [7:0] v);
    @(negedge clk); sel = s; #1 v = rdata;
  endtask

  task automatic lines(input logic c, input logic ds, input logic r, input logic dc);
    @(negedge clk); line_cts = c; line_dsr = ds; line_ri = r; line_dcd = dc;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  function automatic logic [7:0] pins();
    return {3'b0, loop_o, out2_o, out1_o, rts_o, dtr_o};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    peek(1'b0, v); chk("R1 ctl", v, 8'h08);
    peek(1'b1, v); chk("R1 stat", v, 8'hB0);
    chk("R1 pins", pins(), 8'h08);
    chk("R1 msi", {7'b0, msi_req}, 8'h00);
  endtask

  task automatic t_ctl_write();
    logic [7:0] v;
    wr(1'b0, 8'hE7);
    peek(1'b0, v); chk("R2 ctl masked", v, 8'h07);
    chk("R2 pins a", pins(), 8'h07);
    wr(1'b0, 8'h0A);
    peek(1'b0, v); chk("R2 ctl b", v, 8'h0A);
    chk("R2 pins b", pins(), 8'h0A);
    wr(1'b0, 8'h08);
  endtask

  task automatic t_line_change();
    logic [7:0] v;
    lines(1'b0, 1'b1, 1'b0, 1'b1);
    peek(1'b1, v); chk("R3 R4 cts drop", v, 8'hA1);
    chk("R6 msi set", {7'b0, msi_req}, 8'h01);
    rd(1'b1, v); chk("R5 read old", v, 8'hA1);
    peek(1'b1, v); chk("R5 cleared", v, 8'hA0);
    chk("R6 msi clear", {7'b0, msi_req}, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    lines(1'b0, 1'b1, 1'b1, 1'b1);
    peek(1'b1, v); chk("R4 ring rise no flag", v, 8'hE0);
    chk("R4 ring rise msi", {7'b0, msi_req}, 8'h00);
    lines(1'b0, 1'b1, 1'b0, 1'b1);
    peek(1'b1, v); chk("R4 ring fall flag", v, 8'hA4);
    rd(1'b1, v);
  endtask

  task automatic t_accum();
    logic [7:0] v;
    lines(1'b0, 1'b0, 1'b0, 1'b1);
    lines(1'b0, 1'b0, 1'b0, 1'b0);
    peek(1'b1, v); chk("R10 two flags", v, 8'h0A);
    rd(1'b1, v);
    lines(1'b1, 1'b1, 1'b0, 1'b1);
    peek(1'b1, v); chk("R10 three flags", v, 8'hB0 | 8'h0B);
    rd(1'b1, v);
  endtask

  task automatic t_race();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b0;
    repeat (SYNC) @(negedge clk);
    sel = 1'b1; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk("R5 race read old", v, 8'hB0);
    peek(1'b1, v); chk("R5 race flag kept", v, 8'hA1);
    rd(1'b1, v);
    lines(1'b1, 1'b1, 1'b0, 1'b1);
    rd(1'b1, v);
  endtask

  task automatic t_stat_write();
    logic [7:0] v;
    wr(1'b1, 8'hFF);
    peek(1'b1, v); chk("R9 stat unchanged", v, 8'hB0);
    peek(1'b0, v); chk("R9 ctl unchanged", v, 8'h08);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr(1'b0, 8'h16);
    chk("R7 loop pins", pins(), 8'h10);
    peek(1'b1, v); chk("R8 loop view", v, 8'h50);
    lines(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8 no flag in loop", {7'b0, msi_req}, 8'h00);
    wr(1'b0, 8'h08);
    peek(1'b1, v); chk("R8 exit tracked", v, 8'hA0);
    lines(1'b1, 1'b1, 1'b0, 1'b1);
    wr(1'b0, 8'h16);
    rd(1'b1, v); chk("R8 loop read", v, 8'h50);
    chk("R8 flag kept msi", {7'b0, msi_req}, 8'h01);
    wr(1'b0, 8'h08);
    peek(1'b1, v); chk("R8 flag kept", v, 8'hB1);
    rd(1'b1, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctl_write();
    t_line_change();
    t_ring();
    t_accum();
    t_race();
    t_stat_write();
    t_loop();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule